// File: doc/BRIEF.md
# Three-Level Virtual Address Translation Walker

This block turns a 39-bit virtual address into a 56-bit physical address. It reads page table entries from memory, one at a time, starting from the root table named by the translation-control word. A caller hands over one request at a time. Each request carries the virtual address, an access kind (load, store or fetch) and a flag that says whether the access comes from user mode. The walker issues 64-bit entry reads on a valid/ready request channel and takes the data back on a separate valid strobe. It ends with exactly one result: either a physical address, or a page fault with its cause code.

A leaf entry may appear at any of the three levels, which maps a 1 GB, 2 MB or 4 KB page. The walker checks the flag bits of the leaf against the request. The accessed and dirty bits are never updated in hardware: a clear bit only raises a fault. When translation is turned off, the address passes straight through. There is no translation cache here; a surrounding cache or core is expected to provide one.

Top module: `pt_walker`

## Requirements
- R1: When satp bits 63:60 (MODE) are 0 at request acceptance, the result arrives in the cycle after acceptance. It carries no fault, cause 0, and the virtual address zero-extended to 56 bits. No memory read is issued. Any nonzero MODE starts a walk, and satp is sampled only when the request is accepted.
- R2: The first table is at satp bits 43:0 (PPN). Each entry read is at table PPN × 4096 + index × 8. The index is VA bits 38:30 at the first level, 29:21 at the second and 20:12 at the third. The next table PPN is taken from entry bits 53:10.
- R3: Entry flag bits are V=0, R=1, W=2, X=3, U=4, A=6 and D=7. A valid entry with R, W and X all 0 points to the next level. Reaching such an entry at the third level is a fault.
- R4: A successful leaf at level 1, 2 or 3 maps a 1 GB, 2 MB or 4 KB page. The physical address is the leaf PPN with its low 18, 9 or 0 bits replaced by the matching VA bits, followed by VA bits 11:0.
- R5: An entry with V=0, or with W=1 and R=0, faults at once. No further reads follow it.
- R6: A load needs R=1, a store needs W=1 and a fetch needs X=1. A user-mode access also needs U=1. A supervisor access does not look at U.
- R7: A leaf with A=0 faults. A store to a leaf with D=0 faults.
- R8: A 1 GB leaf whose PPN bits 17:0 are not all zero faults. So does a 2 MB leaf whose PPN bits 8:0 are not all zero.
- R9: Access kind is encoded as load=0, store=1 and fetch=2. The fault cause is 13 for a load, 15 for a store and 12 for a fetch. A fault reports physical address 0, and a success reports cause 0.
- R10: The request is accepted only while the walker is idle. At most one entry read is outstanding. A read request holds its address until it is accepted. The result valid is a single-cycle pulse, and the walker is idle again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 39 | Virtual address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_umode | input | 1 | 1 for a user-mode access |
| satp | input | 64 | MODE 63:60, address-space id 59:44, root PPN 43:0 |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 56 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry data |
| rsp_valid | output | 1 | Result pulse |
| rsp_paddr | output | 56 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Page fault |
| rsp_cause | output | 4 | Fault cause, 0 on success |

## Verification
A wrong level counter or table register shows on the memory port first. The very next entry address either leaves the expected sequence or the number of reads is wrong. So the bench compares every read address against its own walk, one request at a time. A wrong leaf decision or permission term appears only in the result pulse, a few cycles later. Each result is checked against an independently computed fault, cause and address. This includes superpage address merging, where a slip in one level's mask corrupts only some address bits.

// File: rtl/pw_pkg.sv
package pw_pkg;
   localparam int FLAG_V = 0;
   localparam int FLAG_R = 1;
   localparam int FLAG_W = 2;
   localparam int FLAG_X = 3;
   localparam int FLAG_U = 4;
   localparam int FLAG_A = 6;
   localparam int FLAG_D = 7;

   localparam int CAUSE_W = 4;

   localparam logic [1:0] ACC_LOAD  = 2'd0;
   localparam logic [1:0] ACC_STORE = 2'd1;
   localparam logic [1:0] ACC_FETCH = 2'd2;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_WAIT,
      ST_DONE
   } walk_st_e;

   function automatic logic [CAUSE_W-1:0] fault_cause(input logic [1:0] acc);
      case (acc)
         ACC_LOAD:  fault_cause = CAUSE_W'(13);
         ACC_STORE: fault_cause = CAUSE_W'(15);
         default:   fault_cause = CAUSE_W'(12);
      endcase
   endfunction
endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
   parameter int LEVELS = 3,
   parameter int IDX_W  = 9,
   parameter int PPN_W  = 44,
   parameter int PTE_SH = 3,
   localparam int VPN_W = LEVELS * IDX_W,
   localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1,
   localparam int ADR_W = PPN_W + IDX_W + PTE_SH
) (
   input  logic [PPN_W-1:0] table_ppn,
   input  logic [VPN_W-1:0] vpn,
   input  logic [LVL_W-1:0] lvl,
   output logic [ADR_W-1:0] pte_addr
);
   logic [IDX_W-1:0] idx [LEVELS];

   for (genvar j = 0; j < LEVELS; j++) begin : g_idx
      assign idx[j] = vpn[j*IDX_W +: IDX_W];
   end

   assign pte_addr = {table_ppn, idx[lvl], {PTE_SH{1'b0}}};
endmodule

// File: rtl/pw_pte_eval.sv
module pw_pte_eval
   import pw_pkg::*;
#(
   parameter int PTE_W   = 64,
   parameter int PPN_W   = 44,
   parameter int PPN_LSB = 10,
   parameter int VA_W    = 39,
   parameter int OFF_W   = 12,
   parameter int IDX_W   = 9,
   parameter int LEVELS  = 3,
   localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1,
   localparam int PA_W   = PPN_W + OFF_W
) (
   input  logic [PTE_W-1:0] pte,
   input  logic [LVL_W-1:0] lvl,
   input  logic [VA_W-1:0]  vaddr,
   input  logic [1:0]       acc,
   input  logic             umode,
   output logic             go_down,
   output logic             fault,
   output logic [PA_W-1:0]  leaf_paddr
);
   logic [PPN_W-1:0] ppn;
   logic             f_v, f_r, f_w, f_x, f_u, f_a, f_d;
   logic             bad_enc, is_leaf, last_lvl, perm_ok, grant;
   logic [LEVELS-1:0] misal;
   logic [PA_W-1:0]  merged [LEVELS];
   logic             unused_pte;

   assign ppn = pte[PPN_LSB +: PPN_W];
   assign f_v = pte[FLAG_V];
   assign f_r = pte[FLAG_R];
   assign f_w = pte[FLAG_W];
   assign f_x = pte[FLAG_X];
   assign f_u = pte[FLAG_U];
   assign f_a = pte[FLAG_A];
   assign f_d = pte[FLAG_D];
   assign unused_pte = ^{pte[PTE_W-1:PPN_LSB+PPN_W], pte[PPN_LSB-1:FLAG_D+1], pte[5]};

   // superpage merge and alignment check, one variant per level
   for (genvar j = 0; j < LEVELS; j++) begin : g_lvl
      if (j == 0) begin : g_base
         assign misal[j]  = 1'b0;
         assign merged[j] = {ppn, vaddr[OFF_W-1:0]};
      end else begin : g_super
         localparam int LO = j * IDX_W;
         assign misal[j]  = |ppn[LO-1:0];
         assign merged[j] = {ppn[PPN_W-1:LO], vaddr[OFF_W+LO-1:0]};
      end
   end

   always_comb begin
      case (acc)
         ACC_LOAD:  perm_ok = f_r;
         ACC_STORE: perm_ok = f_w;
         default:   perm_ok = f_x;
      endcase
   end

   assign bad_enc  = !f_v || (f_w && !f_r);
   assign is_leaf  = f_r || f_x;
   assign last_lvl = (lvl == '0);
   assign grant    = perm_ok && (!umode || f_u) && f_a &&
                     !((acc == ACC_STORE) && !f_d) && !misal[lvl];

   assign fault      = bad_enc || (is_leaf && !grant) || (!is_leaf && last_lvl);
   assign go_down    = !bad_enc && !is_leaf && !last_lvl;
   assign leaf_paddr = merged[lvl];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import pw_pkg::*;
#(
   parameter int VA_W    = 39,
   parameter int PA_W    = 56,
   parameter int PTE_W   = 64,
   parameter int SATP_W  = 64,
   parameter int MODE_W  = 4,
   parameter int LEVELS  = 3,
   parameter int IDX_W   = 9,
   parameter int OFF_W   = 12,
   parameter int PTE_SH  = 3,
   parameter int PPN_LSB = 10,
   localparam int PPN_W  = PA_W - OFF_W,
   localparam int VPN_W  = LEVELS * IDX_W,
   localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_vaddr,
   input  logic [1:0]        req_acc,
   input  logic              req_umode,
   input  logic [SATP_W-1:0] satp,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [PA_W-1:0]   mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [PTE_W-1:0]  mem_rsp_data,
   output logic              rsp_valid,
   output logic [PA_W-1:0]   rsp_paddr,
   output logic              rsp_fault,
   output logic [CAUSE_W-1:0] rsp_cause
);
   if (VA_W != OFF_W + VPN_W) begin : g_chk_va
      $error("virtual width must equal offset plus all indices");
   end
   if (IDX_W + PTE_SH != OFF_W) begin : g_chk_tbl
      $error("one table must fill exactly one page");
   end
   if (PA_W <= VA_W) begin : g_chk_pa
      $error("physical width must exceed virtual width");
   end
   if (PTE_W < PPN_LSB + PPN_W || SATP_W < PPN_W + MODE_W) begin : g_chk_fld
      $error("entry or control word too narrow for PPN");
   end

   walk_st_e          st;
   logic [LVL_W-1:0]  lvl;
   logic [PPN_W-1:0]  tbl;
   logic [VA_W-1:0]   va_q;
   logic [1:0]        acc_q;
   logic              um_q;
   logic [PA_W-1:0]   pa_q;
   logic              flt_q;
   logic [CAUSE_W-1:0] cause_q;

   logic              ev_down, ev_fault;
   logic [PA_W-1:0]   ev_paddr;
   logic              bare;
   logic              unused_satp;

   assign bare        = (satp[SATP_W-1 -: MODE_W] == '0);
   assign unused_satp = ^satp[SATP_W-MODE_W-1:PPN_W];

   pw_addr_gen #(
      .LEVELS(LEVELS), .IDX_W(IDX_W), .PPN_W(PPN_W), .PTE_SH(PTE_SH)
   ) u_addr (
      .table_ppn(tbl),
      .vpn      (va_q[VA_W-1:OFF_W]),
      .lvl      (lvl),
      .pte_addr (mem_req_addr)
   );

   pw_pte_eval #(
      .PTE_W(PTE_W), .PPN_W(PPN_W), .PPN_LSB(PPN_LSB), .VA_W(VA_W),
      .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS)
   ) u_eval (
      .pte       (mem_rsp_data),
      .lvl       (lvl),
      .vaddr     (va_q),
      .acc       (acc_q),
      .umode     (um_q),
      .go_down   (ev_down),
      .fault     (ev_fault),
      .leaf_paddr(ev_paddr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         lvl     <= '0;
         tbl     <= '0;
         va_q    <= '0;
         acc_q   <= '0;
         um_q    <= 1'b0;
         pa_q    <= '0;
         flt_q   <= 1'b0;
         cause_q <= '0;
      end else begin
         case (st)
            ST_IDLE: if (req_valid) begin
               va_q  <= req_vaddr;
               acc_q <= req_acc;
               um_q  <= req_umode;
               if (bare) begin
                  pa_q    <= {{(PA_W-VA_W){1'b0}}, req_vaddr};
                  flt_q   <= 1'b0;
                  cause_q <= '0;
                  st      <= ST_DONE;
               end else begin
                  tbl <= satp[PPN_W-1:0];
                  lvl <= LVL_W'(LEVELS-1);
                  st  <= ST_ISSUE;
               end
            end
            ST_ISSUE: if (mem_req_ready) st <= ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) begin
               if (ev_fault) begin
                  pa_q    <= '0;
                  flt_q   <= 1'b1;
                  cause_q <= fault_cause(acc_q);
                  st      <= ST_DONE;
               end else if (ev_down) begin
                  tbl <= mem_rsp_data[PPN_LSB +: PPN_W];
                  lvl <= lvl - 1'b1;
                  st  <= ST_ISSUE;
               end else begin
                  pa_q    <= ev_paddr;
                  flt_q   <= 1'b0;
                  cause_q <= '0;
                  st      <= ST_DONE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign req_ready     = (st == ST_IDLE);
   assign mem_req_valid = (st == ST_ISSUE);
   assign rsp_valid     = (st == ST_DONE);
   assign rsp_paddr     = pa_q;
   assign rsp_fault     = flt_q;
   assign rsp_cause     = cause_q;

   p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid && req_ready);
   p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req_valid && !rsp_valid);
   p_entry_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> mem_req_addr[PTE_SH-1:0] == '0);
   p_bare_direct_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && bare |=> rsp_valid && !rsp_fault && !mem_req_valid);
   p_cause_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault |-> rsp_cause == fault_cause(acc_q) && rsp_paddr == '0);
   p_ok_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_fault |-> rsp_cause == '0);
endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic        req_ready;
   logic [38:0] req_vaddr;
   logic [1:0]  req_acc;
   logic        req_umode;
   logic [63:0] satp;
   logic        mem_req_valid;
   logic        mem_req_ready;
   logic [55:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [63:0] mem_rsp_data;
   logic        rsp_valid;
   logic [55:0] rsp_paddr;
   logic        rsp_fault;
   logic [3:0]  rsp_cause;

   int total = 0;
   int bad   = 0;
   bit finished = 0;

   logic [63:0] pmem [logic [55:0]];
   logic [55:0] exp_q [$];
   logic [55:0] got_q [$];
   logic        hs;
   logic [55:0] hs_addr;

   localparam logic [7:0] FV = 8'h01, FR = 8'h02, FW = 8'h04, FX = 8'h08,
                          FU = 8'h10, FA = 8'h40, FD = 8'h80;
   localparam logic [43:0] ROOT = 44'h00080;
   localparam logic [63:0] SP39 = {4'h8, 16'h0042, ROOT};

   pt_walker dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_acc(req_acc), .req_umode(req_umode), .satp(satp),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid),
      .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
   );

   always #2.5 clk = ~clk;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs      <= 1'b0;
         hs_addr <= '0;
      end else begin
         hs      <= mem_req_valid && mem_req_ready;
         hs_addr <= mem_req_addr;
      end
   end

   // memory model: random accept stall and 0..2 extra cycles of read latency
   initial begin
      bit          pend;
      int          dly;
      logic [63:0] rd;
      pend = 0; dly = 0; rd = '0;
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (hs) begin
            got_q.push_back(hs_addr);
            pend = 1;
            dly  = int'($urandom % 3);
            rd   = pmem.exists(hs_addr) ? pmem[hs_addr] : 64'h0;
         end
         if (pend) begin
            if (dly == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = rd;
               pend = 0;
            end else begin
               dly--;
            end
         end
         mem_req_ready = !pend && ($urandom % 4 != 0);
      end
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic ref_walk(input logic [38:0] va, input logic [1:0] acc,
                           input logic um, input logic [63:0] sp,
                           output logic f, output logic [3:0] c,
                           output logic [55:0] pa);
      logic [43:0] tbl, ppn, mask;
      logic [55:0] addr;
      logic [63:0] pte;
      logic [8:0]  idx;
      logic        ok;
      bit          done;
      exp_q.delete();
      f = 0; c = 4'd0; pa = '0; done = 0;
      if (sp[63:60] == 4'h0) begin
         pa = {17'b0, va};
      end else begin
         tbl = sp[43:0];
         for (int l = 2; l >= 0 && !done; l--) begin
            idx  = va[12 + 9*l +: 9];
            addr = {tbl, 12'h0} + 56'(idx) * 56'd8;
            exp_q.push_back(addr);
            pte = pmem.exists(addr) ? pmem[addr] : 64'h0;
            ppn = pte[53:10];
            if (!pte[0] || (pte[2] && !pte[1])) begin
               f = 1; done = 1;
            end else if (pte[1] || pte[3]) begin
               ok = (acc == 2'd0) ? pte[1] : (acc == 2'd1) ? pte[2] : pte[3];
               if (um && !pte[4]) ok = 0;
               if (!pte[6]) ok = 0;
               if (acc == 2'd1 && !pte[7]) ok = 0;
               mask = (44'd1 << (9*l)) - 44'd1;
               if ((ppn & mask) != 0) ok = 0;
               if (ok) pa = {(ppn & ~mask) | ({17'b0, va[38:12]} & mask), va[11:0]};
               else f = 1;
               done = 1;
            end else if (l == 0) begin
               f = 1; done = 1;
            end else begin
               tbl = ppn;
            end
         end
         if (f) c = (acc == 2'd0) ? 4'd13 : (acc == 2'd1) ? 4'd15 : 4'd12;
      end
   endtask

   task automatic map_va(input logic [38:0] va, input int leaf_l,
                         input logic [7:0] lflags, input logic [43:0] lppn);
      logic [43:0] tbl, nxt;
      logic [55:0] addr;
      tbl = ROOT;
      for (int l = 2; l > leaf_l; l--) begin
         addr = {tbl, va[12 + 9*l +: 9], 3'b000};
         nxt  = 44'h1000 + 44'($urandom % 4096);
         pmem[addr] = {10'b0, nxt, 10'h001};
         tbl = nxt;
      end
      addr = {tbl, va[12 + 9*leaf_l +: 9], 3'b000};
      pmem[addr] = {10'b0, lppn, 2'b00, lflags};
   endtask

   task automatic run_txn(input logic [38:0] va, input logic [1:0] acc,
                          input logic um, input logic [63:0] sp, input string tag);
      logic        ef;
      logic [3:0]  ec;
      logic [55:0] ep;
      bit          busy_bad, addr_ok;
      int          n;
      ref_walk(va, acc, um, sp, ef, ec, ep);
      got_q.delete();
      @(negedge clk);
      satp = sp; req_vaddr = va; req_acc = acc; req_umode = um;
      busy_bad = !req_ready;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (!rsp_valid && n < 400) begin
         if (req_ready) busy_bad = 1;
         @(negedge clk);
         n++;
      end
      check(rsp_valid && rsp_fault == ef && rsp_cause == ec && rsp_paddr == ep, tag,
            "result {fault,cause,paddr}",
            {3'b0, rsp_fault, rsp_cause, rsp_paddr}, {3'b0, ef, ec, ep});
      addr_ok = (got_q.size() == exp_q.size());
      for (int i = 0; i < got_q.size() && addr_ok; i++)
         if (got_q[i] != exp_q[i]) addr_ok = 0;
      check(addr_ok, "R2", "entry read sequence {count,first}",
            {32'(got_q.size()), (got_q.size() > 0) ? 32'(got_q[0]) : 32'h0},
            {32'(exp_q.size()), (exp_q.size() > 0) ? 32'(exp_q[0]) : 32'h0});
      @(negedge clk);
      check(!busy_bad && !rsp_valid && req_ready, "R10", "busy/pulse {busy_bad,valid,ready}",
            {61'b0, busy_bad, rsp_valid, req_ready}, 64'h1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: got hung expected finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      rst_n = 1'b0;
      req_valid = 1'b0; req_vaddr = '0; req_acc = '0; req_umode = 1'b0; satp = '0;
      repeat (4) @(negedge clk);
      check(req_ready && !rsp_valid && !mem_req_valid, "R10", "reset {ready,rsp,memreq}",
            {61'b0, req_ready, rsp_valid, mem_req_valid}, 64'h4);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: bare mode, also with address-space id bits set
      run_txn(39'h12_3456_789A, 2'd0, 1'b0, 64'h0, "R1");
      run_txn(39'h7F_FFFF_F001, 2'd1, 1'b1, 64'h0000_FFFF_0000_1234, "R1");
      // R4 and R2: 4 KB, 2 MB, 1 GB successes
      map_va(39'h00_4020_3ABC, 0, FV|FR|FA, 44'h12345);
      run_txn(39'h00_4020_3ABC, 2'd0, 1'b0, SP39, "R4");
      map_va(39'h01_8060_1123, 1, FV|FR|FW|FX|FA|FD, 44'hABC00);
      run_txn(39'h01_8060_1123, 2'd1, 1'b0, SP39, "R4");
      map_va(39'h55_2345_6789, 2, FV|FX|FA|FU, 44'h540000);
      run_txn(39'h55_2345_6789, 2'd2, 1'b1, SP39, "R4");
      // R5: invalid and write-without-read encodings
      map_va(39'h3A_0000_0010, 2, 8'h00, 44'h1);
      run_txn(39'h3A_0000_0010, 2'd0, 1'b0, SP39, "R5");
      map_va(39'h22_1111_0020, 1, FV|FW|FA|FD, 44'h00200);
      run_txn(39'h22_1111_0020, 2'd1, 1'b0, SP39, "R5");
      // R6: missing execute, user without U, supervisor on a U page
      map_va(39'h10_0101_0030, 0, FV|FR|FA, 44'h00777);
      run_txn(39'h10_0101_0030, 2'd2, 1'b0, SP39, "R6");
      map_va(39'h10_0202_0040, 0, FV|FR|FW|FA|FD, 44'h00778);
      run_txn(39'h10_0202_0040, 2'd0, 1'b1, SP39, "R6");
      map_va(39'h10_0303_0050, 0, FV|FR|FU|FA, 44'h00779);
      run_txn(39'h10_0303_0050, 2'd0, 1'b0, SP39, "R6");
      // R7: accessed clear, dirty clear on store, dirty clear on load is fine
      map_va(39'h31_0404_0060, 0, FV|FR|FW, 44'h0077A);
      run_txn(39'h31_0404_0060, 2'd0, 1'b0, SP39, "R7");
      map_va(39'h31_0505_0070, 0, FV|FR|FW|FA, 44'h0077B);
      run_txn(39'h31_0505_0070, 2'd1, 1'b0, SP39, "R7");
      run_txn(39'h31_0505_0070, 2'd0, 1'b0, SP39, "R7");
      // R8: misaligned 2 MB and 1 GB leaves
      map_va(39'h44_0606_0080, 1, FV|FR|FA, 44'h00101);
      run_txn(39'h44_0606_0080, 2'd0, 1'b0, SP39, "R8");
      map_va(39'h66_0707_0090, 2, FV|FR|FA, 44'h40200);
      run_txn(39'h66_0707_0090, 2'd0, 1'b0, SP39, "R8");
      // R3: pointer at last level
      map_va(39'h70_0808_00A0, 0, FV, 44'h00123);
      run_txn(39'h70_0808_00A0, 2'd0, 1'b0, SP39, "R3");
      // R9: cause per access kind on the same faulting page
      map_va(39'h05_0909_00B0, 0, FV|FA|FD, 44'h00999);
      run_txn(39'h05_0909_00B0, 2'd0, 1'b0, SP39, "R9");
      run_txn(39'h05_0909_00B0, 2'd1, 1'b0, SP39, "R9");
      run_txn(39'h05_0909_00B0, 2'd2, 1'b0, SP39, "R9");

      // random mix
      for (int t = 0; t < 300; t++) begin
         logic [38:0] va;
         logic [7:0]  fl;
         logic [43:0] pp;
         logic [63:0] sp;
         int          ll;
         va = {$urandom, $urandom} & 39'h7F_FFFF_FFFF;
         ll = int'($urandom % 3);
         fl = ($urandom % 6 == 0) ? 8'($urandom) : (FV | FA | 8'($urandom & 32'hBE));
         if (($urandom % 8) == 0) fl = FV;
         pp = {12'h0, $urandom};
         if (($urandom % 4) != 0) pp = pp & ~((44'd1 << (9*ll)) - 44'd1);
         map_va(va, ll, fl, pp);
         sp = (($urandom % 10) == 0) ? {4'h0, 16'($urandom), ROOT} : SP39;
         run_txn(va, 2'($urandom % 3), 1'($urandom), sp, "R6");
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule